// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system use an external asynchronous static RAM of 32768 eight-bit words. A host issues single-word read or write requests on a small request port. The controller then drives the memory's 15 address lines and its three active-low strobes (chip select, output enable, write enable). It also owns its side of the shared 8-bit data bus, which it drives or releases as the cycle requires.

Every memory timing constraint is a nanosecond parameter. The controller converts each one into a whole number of clock cycles, rounding up. Reads hold the strobes long enough to cover both the read-cycle time and the output-enable access time. Writes hold a write pulse of configurable width, followed by one cycle of address and data hold. After every read, the controller waits out the memory's output-float time before it can drive the bus again. Between accesses the memory is always deselected so that it drops into standby. After reset, the controller waits one full read-cycle time before it accepts any work, which gives the memory time to recover from a low-supply retention period.

A request is taken only in an idle cycle, and the cycle in which `done` is high counts as idle. Requests arriving at any other time are dropped.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and for 8 cycles after it falls (one read-cycle time at the default 20 ns clock), all three memory strobes are high and `done` is low. A request presented in that window is discarded: no strobe ever falls for it and no `done` is produced.
- R2: Whenever no access is in progress, chip select is high, output enable and write enable are high, and the controller does not drive the data bus.
- R3: A read holds chip select and output enable low and write enable high for exactly 8 cycles at defaults. It then captures the bus into `rsp_rdata`, and that value equals the addressed word.
- R4: A write holds chip select and write enable low for exactly 5 cycles at defaults (100 ns pulse). Output enable stays high and the bus carries `req_wdata`.
- R5: After write enable rises, chip select stays low and the address and data stay driven for exactly one more cycle. The address never changes while chip select is low.
- R6: After output enable rises at the end of a read, the controller neither drives the bus nor lowers write enable for at least 2 cycles (35 ns float time rounded up).
- R7: `done` is a one-cycle pulse. It is seen 10 cycles after the accepting edge for a read and 6 cycles after it for a write. A request presented while `done` is high is accepted.
- R8: A request presented while an access is in progress is ignored. It produces no extra `done`, no extra memory cycle and no change to memory contents.
- R9: `rsp_rdata` keeps the last read value until the next read completes. A write does not alter it.
- R10: Output enable and write enable are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Data to write |
| rsp_rdata | output | 8 | Last word read from memory |
| done | output | 1 | One-cycle pulse marking completion and return to idle |
| mem_addr | output | 15 | Memory address lines |
| mem_dq | inout | 8 | Shared memory data bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The controller is exercised with isolated writes and reads to addresses that differ in both high and low address bits. The data patterns are all-zeros, all-ones and mixed values, so that address, data and strobe-width faults show up separately in the returned words and in the counted strobe cycles. A read followed immediately by a write, issued in the `done` cycle, separates a correct float gap from a shortened one. A request injected in the middle of a read, and another injected straight after reset, show whether busy-time and recovery-time requests are really dropped. A write issued after a read shows whether the captured read data is preserved.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_RECOV,
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD,
    ST_FLOAT
  } asram_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/asram_iopath.sv
module asram_iopath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          release_bus,
  input  logic          capture,
  inout  wire  [DW-1:0] dq,
  output logic [DW-1:0] rd_data,
  output logic          driving
);

  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      driving <= 1'b0;
      out_q   <= '0;
      rd_data <= '0;
    end else begin
      if (load_wr) begin
        driving <= 1'b1;
        out_q   <= wr_data;
      end else if (release_bus) begin
        driving <= 1'b0;
      end
      if (capture) begin
        rd_data <= dq;
      end
    end
  end

  assign dq = driving ? out_q : {DW{1'bz}};

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 20,
  parameter int T_CYCLE_NS  = 150,
  parameter int T_OEACC_NS  = 100,
  parameter int T_OEFLT_NS  = 30,
  parameter int T_CSFLT_NS  = 35,
  parameter int T_WPULSE_NS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int RD_CYC  = imax(ns_to_cyc(T_CYCLE_NS, CLK_NS), ns_to_cyc(T_OEACC_NS, CLK_NS));
  localparam int TA_CYC  = ns_to_cyc(imax(T_OEFLT_NS, T_CSFLT_NS), CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(T_WPULSE_NS, CLK_NS);
  localparam int REC_CYC = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int CNT_MAX = imax(imax(RD_CYC, TA_CYC), imax(WP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  asram_state_t      state;
  logic              t_exp;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              io_load;
  logic              io_release;
  logic              io_capture;
  logic              bus_drive;

  asram_timer #(.CW(CNT_W), .RST_VAL(REC_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  asram_iopath #(.DW(DATA_W)) u_io (
    .clk         (clk),
    .rst         (rst),
    .load_wr     (io_load),
    .wr_data     (req_wdata),
    .release_bus (io_release),
    .capture     (io_capture),
    .dq          (mem_dq),
    .rd_data     (rsp_rdata),
    .driving     (bus_drive)
  );

  // timer and data-path control for the current state
  always_comb begin
    t_load     = 1'b0;
    t_val      = '0;
    io_load    = 1'b0;
    io_release = 1'b0;
    io_capture = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          t_load  = 1'b1;
          t_val   = req_we ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
          io_load = req_we;
        end
      end
      ST_READ: begin
        if (t_exp) begin
          io_capture = 1'b1;
          t_load     = 1'b1;
          t_val      = CNT_W'(TA_CYC - 1);
        end
      end
      ST_WHOLD: io_release = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RECOV;
      mem_cs_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_addr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_RECOV: if (t_exp) state <= ST_IDLE;
        ST_IDLE: begin
          if (req) begin
            mem_addr <= req_addr;
            mem_cs_n <= 1'b0;
            if (req_we) begin
              mem_we_n <= 1'b0;
              state    <= ST_WPULSE;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (t_exp) begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= ST_FLOAT;
          end
        end
        ST_FLOAT: begin
          if (t_exp) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WPULSE: begin
          if (t_exp) begin
            mem_we_n <= 1'b1;
            state    <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          mem_cs_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int RD_CYC = 8,
  parameter int TA_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_drv,
  input logic              done
);

  logic [7:0] oe_low_cnt;
  logic [7:0] oe_high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_low_cnt  <= 8'd0;
      oe_high_cnt <= 8'hFF;
    end else begin
      if (mem_oe_n) oe_low_cnt <= 8'd0;
      else if (oe_low_cnt != 8'hFF) oe_low_cnt <= oe_low_cnt + 8'd1;
      if (!mem_oe_n) oe_high_cnt <= 8'd0;
      else if (oe_high_cnt != 8'hFF) oe_high_cnt <= oe_high_cnt + 8'd1;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_oe_n && mem_we_n && !bus_drv));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (bus_drv && mem_oe_n && !mem_cs_n));

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && bus_drv));

  assert_read_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (int'(oe_low_cnt) >= RD_CYC));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_drv) |-> (int'(oe_high_cnt) >= TA_CYC));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .RD_CYC (RD_CYC),
  .TA_CYC (TA_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_cs_n (mem_cs_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr),
  .bus_drv  (bus_drive),
  .done     (done)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

  localparam int RD_EXP   = 8;
  localparam int WP_EXP   = 5;
  localparam int TA_EXP   = 2;
  localparam int RD_LAT   = RD_EXP + TA_EXP + 1;  // negedges until done seen
  localparam int WR_LAT   = WP_EXP + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        done;
  logic [14:0] mem_addr;
  wire  [7:0]  mem_dq;
  logic        mem_cs_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;
  int oe_gap = 0;
  int last_gap = 0;
  logic we_prev = 1'b1;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .done(done),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // behavioural memory, 64 words indexed by the low address bits
  assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? model[mem_addr[5:0]] : 8'bz;

  always @(posedge mem_we_n) begin
    if (mem_cs_n == 1'b0) model[mem_addr[5:0]] <= mem_dq;
  end

  // cycles since output enable was last low, and its value when write enable falls
  always @(negedge clk) begin
    if (mem_oe_n) oe_gap = oe_gap + 1;
    else oe_gap = 0;
    if (!mem_we_n && we_prev) last_gap = oe_gap;
    we_prev = mem_we_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        output int lat, output int strobe, output int hold, output int bad);
    req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
    lat = 0; strobe = 0; hold = 0; bad = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      req = 1'b0;
      if (!mem_cs_n) begin
        if (mem_addr !== a) bad++;
        if (wr) begin
          if (!mem_oe_n) bad++;
          if (!mem_we_n) begin
            strobe++;
            if (mem_dq !== d) bad++;
          end else hold++;
        end else begin
          if (!mem_we_n) bad++;
          if (!mem_oe_n) strobe++;
        end
      end
      if (done) begin
        lat = n;
        break;
      end
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int lat, strobe, hold, bad;
    access(1'b1, a, d, lat, strobe, hold, bad);
    chk("R7 write latency", lat, WR_LAT);
    chk("R4 write pulse cycles", strobe, WP_EXP);
    chk("R5 write hold cycles", hold, 1);
    chk("R4 R5 write address/data/oe faults", bad, 0);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
    int lat, strobe, hold, bad;
    access(1'b0, a, 8'h00, lat, strobe, hold, bad);
    chk("R7 read latency", lat, RD_LAT);
    chk("R3 read strobe cycles", strobe, RD_EXP);
    chk("R3 read address/we faults", bad, 0);
    chk("R3 read data", rsp_rdata, exp);
  endtask

  task automatic t_reset;
    int busy;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n in reset", mem_cs_n, 1);
    chk("R1 oe_n in reset", mem_oe_n, 1);
    chk("R1 we_n in reset", mem_we_n, 1);
    chk("R1 done in reset", done, 0);
    rst = 1'b0;
    req = 1'b1; req_we = 1'b0; req_addr = 15'h0003;
    busy = 0;
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      req = 1'b0;
      if (!mem_cs_n || !mem_oe_n || !mem_we_n || done) busy++;
    end
    chk("R1 request during recovery ignored", busy, 0);
  endtask

  task automatic t_basic;
    do_write(15'h7FC1, 8'h5A);
    chk("R2 idle cs_n after write", mem_cs_n, 1);
    do_read(15'h7FC1, 8'h5A);
    @(negedge clk);
    chk("R2 idle strobes after read", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk("R7 done single pulse", done, 0);
  endtask

  task automatic t_patterns;
    do_write(15'h0002, 8'hA5);
    do_write(15'h4003, 8'h3C);
    do_write(15'h3E3E, 8'hFF);
    do_write(15'h0015, 8'h00);
    do_read(15'h0002, 8'hA5);
    do_read(15'h4003, 8'h3C);
    do_read(15'h3E3E, 8'hFF);
    do_read(15'h0015, 8'h00);
  endtask

  task automatic t_turnaround;
    do_read(15'h4003, 8'h3C);
    do_write(15'h0020, 8'h96);   // issued in the done cycle (R7)
    chk("R6 cycles from oe_n rise to write drive", last_gap, TA_EXP + 2);
    chk("R9 rdata kept across write", rsp_rdata, 8'h3C);
    do_read(15'h0020, 8'h96);
  endtask

  task automatic t_busy;
    int extra, cs_low, lat;
    do_write(15'h0009, 8'h11);
    do_write(15'h000A, 8'h22);
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 15'h0009;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 15'h000A; req_wdata = 8'h77;
    @(negedge clk); req = 1'b0;
    lat = 0;
    for (int n = 0; n < 40; n++) begin
      if (done) begin lat = 1; break; end
      @(negedge clk);
    end
    chk("R8 first read completes", lat, 1);
    chk("R8 read value", rsp_rdata, 8'h11);
    extra = 0; cs_low = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (done) extra++;
      if (!mem_cs_n) cs_low++;
    end
    chk("R8 no extra done", extra, 0);
    chk("R8 no extra memory cycle", cs_low, 0);
    do_read(15'h000A, 8'h22);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    t_reset();
    @(negedge clk);
    t_basic();
    t_patterns();
    t_turnaround();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule